// File: doc/BRIEF.md
# Common-Interface Card Access Bridge

This block sits between a simple byte-wide host register port and two removable conditional-access card slots. The host first loads a 14-bit card address, split over two address registers, and then programs a control register. That register picks the target slot, picks the space (card control space or attribute memory), starts per-slot card resets and turns per-slot transport stream routing on or off. A read or write of the data register then starts exactly one card cycle at the latched address. While that cycle runs, the host ready signal stays low. When the cycle ends, ready returns, and for a read the card byte is already in the host read data.

Card-detect inputs are synchronised and shown as read-only status bits in the control register. Any change of card-detect raises a pending interrupt, which a read of the interrupt register returns and clears. The card-side timing is a fixed-length strobe: one chip-select and one read or write strobe held for a parameter number of core cycles. Card resets are driven for a parameter number of cycles, and the request bit clears itself when the reset ends.

Top module: `ci_card_bridge`

## Requirements
- R1: The card address is {HI[6:0], LO[7:1]}. It uses address register LO (index 0) bits 7:1 as card bits 6:0 and register HI (index 1) bits 6:0 as card bits 13:7. LO bit 0 is ignored and reads back as 0. The address stays stable for the whole card cycle.
- R2: Control register (index 3) bit 7 selects the slot: 0 asserts card_ce_n[0] and 1 asserts card_ce_n[1]. Bit 6 drives card_ctl_space (1 selects control space, 0 selects attribute memory). At most one chip-select is low at a time.
- R3: A host read of the data register (index 2) produces a card read strobe (card_oe_n low). A host write produces a write strobe (card_we_n low) carrying the host byte on card_wdata. The two strobes are never low together.
- R4: Each card cycle holds its strobe for exactly WAIT_CYCLES clock cycles. host_ready is low for the same cycles. A data read returns the card byte sampled at the end of the strobe.
- R5: Writing 1 to control bit 5 (slot 0) or bit 4 (slot 1) drives card_rst for that slot for exactly RESET_CYCLES cycles. The bit reads 1 during that time and clears by itself afterwards. Writing 0 while a reset runs does not shorten it.
- R6: Control bit 3 drives ts_en[0] and control bit 2 drives ts_en[1].
- R7: Control bit 1 reports card_det_n[0] and control bit 0 reports card_det_n[1], where 0 means a card is present. Host writes to these two bits are ignored.
- R8: Any change of the synchronised card-detect value sets irq. A read of the interrupt register (index 4) returns the pending flag in bit 0 and clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Host register access request, taken when host_ready is high |
| host_wr | input | 1 | 1 for write, 0 for read |
| host_addr | input | 3 | Register index |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| host_ready | output | 1 | Low while a card cycle is in progress |
| irq | output | 1 | Pending card-detect change interrupt |
| card_addr | output | 14 | Card address |
| card_wdata | output | 8 | Byte driven to the card on a write |
| card_rdata | input | 8 | Byte returned by the card |
| card_ce_n | output | 2 | Per-slot active-low chip select |
| card_ctl_space | output | 1 | 1 for control space, 0 for attribute memory |
| card_oe_n | output | 1 | Active-low read strobe |
| card_we_n | output | 1 | Active-low write strobe |
| card_rst | output | 2 | Per-slot card reset, active high |
| card_det_n | input | 2 | Per-slot card detect, 0 when a card is inserted |
| ts_en | output | 2 | Per-slot transport stream enable |

## Verification
The card-cycle path is swept over all four slot and space combinations, against address patterns that include all zeros, all ones and a walk of mixed values. LO bit 0 is toggled along the way, so wrong shifts, swapped halves or a leaking unused bit each produce a different wrong address or read byte. The bench's card model returns a byte derived from the address, slot and space, so a wrong chip-select or space line shows up in the data as well as at the pins. Reset requests are timed per slot, including a write of 0 during a running reset, and card-detect patterns check the bit order of the status bits, the ignored status writes and the set and clear of the interrupt.

// File: rtl/ci_bridge_pkg.sv
package ci_bridge_pkg;

   localparam int HOST_DW    = 8;
   localparam int IDX_W      = 3;
   localparam int ADDR_LO_W  = 7;
   localparam int ADDR_HI_W  = 7;
   localparam int CARD_AW    = ADDR_LO_W + ADDR_HI_W;
   localparam int NUM_SLOTS  = 2;

   typedef enum logic [IDX_W-1:0] {
      RA_ADDR_LO = 3'd0,
      RA_ADDR_HI = 3'd1,
      RA_DATA    = 3'd2,
      RA_CTRL    = 3'd3,
      RA_IRQ     = 3'd4
   } reg_idx_e;

   // control byte bit positions; per-slot fields count down from slot 0
   localparam int CB_SLOT  = 7;
   localparam int CB_SPACE = 6;
   localparam int CB_RST0  = 5;
   localparam int CB_TS0   = 3;
   localparam int CB_DET0  = 1;

endpackage

// File: rtl/ci_card_cycle.sv
module ci_card_cycle #(
   parameter int ADDR_W      = 14,
   parameter int DATA_W      = 8,
   parameter int SLOTS       = 2,
   parameter int WAIT_CYCLES = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic [SEL_W-1:0]           slot_i,
   input  logic                       space_i,
   input  logic                       write_i,
   input  logic [ADDR_W-1:0]          addr_i,
   input  logic [DATA_W-1:0]          wdata_i,
   output logic                       busy_o,
   output logic                       done_o,
   output logic                       write_o,
   output logic [ADDR_W-1:0]          card_addr_o,
   output logic [DATA_W-1:0]          card_wdata_o,
   output logic [SLOTS-1:0]           card_ce_n_o,
   output logic                       card_space_o,
   output logic                       card_oe_n_o,
   output logic                       card_we_n_o
);
   localparam int SEL_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

   if (WAIT_CYCLES < 1) begin : g_bad_wait
      $error("WAIT_CYCLES must be at least 1");
   end
   if (SLOTS < 1) begin : g_bad_slots
      $error("SLOTS must be at least 1");
   end

   logic              busy_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [SEL_W-1:0]  slot_q;
   logic              space_q;
   logic              write_q;
   logic              last_cycle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         slot_q  <= '0;
         space_q <= 1'b0;
         write_q <= 1'b0;
      end else if (start_i && !busy_q) begin
         addr_q  <= addr_i;
         wdata_q <= wdata_i;
         slot_q  <= slot_i;
         space_q <= space_i;
         write_q <= write_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 busy_q <= 1'b0;
      else if (start_i && !busy_q) busy_q <= 1'b1;
      else if (busy_q && last_cycle) busy_q <= 1'b0;
   end

   // wait-count variant: a single-cycle strobe needs no counter
   if (WAIT_CYCLES == 1) begin : g_no_count
      assign last_cycle = 1'b1;
   end else begin : g_count
      localparam int CNT_W = $clog2(WAIT_CYCLES);
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  cnt_q <= '0;
         else if (start_i && !busy_q) cnt_q <= CNT_W'(WAIT_CYCLES - 1);
         else if (busy_q && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
      assign last_cycle = (cnt_q == '0);
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_ce
      assign card_ce_n_o[s] = !(busy_q && (slot_q == SEL_W'(s)));
   end

   assign busy_o       = busy_q;
   assign done_o       = busy_q && last_cycle;
   assign write_o      = write_q;
   assign card_addr_o  = addr_q;
   assign card_wdata_o = wdata_q;
   assign card_space_o = space_q;
   assign card_oe_n_o  = !(busy_q && !write_q);
   assign card_we_n_o  = !(busy_q && write_q);

   AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~card_ce_n_o)); // R2
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!card_oe_n_o && !card_we_n_o)); // R3
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && $past(busy_q) |-> $stable(card_addr_o)); // R1
   AST_START_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_q |=> !card_oe_n_o || !card_we_n_o); // R3

endmodule

// File: rtl/ci_slot_reset.sv
module ci_slot_reset #(
   parameter int RESET_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic active_o
);
   localparam int CNT_W = (RESET_CYCLES > 1) ? $clog2(RESET_CYCLES) : 1;

   if (RESET_CYCLES < 1) begin : g_bad_len
      $error("RESET_CYCLES must be at least 1");
   end

   logic             active_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (!active_q) begin
         if (start_i) begin
            active_q <= 1'b1;
            cnt_q    <= CNT_W'(RESET_CYCLES - 1);
         end
      end else if (cnt_q == '0) begin
         active_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign active_o = active_q;

   AST_RST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      active_q && cnt_q == '0 |=> !active_q); // R5
   AST_RST_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !active_q |=> active_q); // R5

endmodule

// File: rtl/ci_detect_mon.sv
module ci_detect_mon #(
   parameter int WIDTH       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] det_n_i,
   input  logic             clear_i,
   output logic [WIDTH-1:0] det_n_s_o,
   output logic             pend_o
);
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("SYNC_STAGES must not be negative");
   end

   logic [WIDTH-1:0] det_s;
   logic [WIDTH-1:0] prev_q;
   logic             change;
   logic             pend_q;

   if (SYNC_STAGES == 0) begin : g_direct
      assign det_s = det_n_i;
   end else begin : g_sync
      logic [WIDTH-1:0] stg_q [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stg_q[i] <= '1;
         end else begin
            stg_q[0] <= det_n_i;
            for (int i = 1; i < SYNC_STAGES; i++) stg_q[i] <= stg_q[i-1];
         end
      end
      assign det_s = stg_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '1;
      else        prev_q <= det_s;
   end

   assign change = (det_s != prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_q <= 1'b0;
      else if (change)  pend_q <= 1'b1;
      else if (clear_i) pend_q <= 1'b0;
   end

   assign det_n_s_o = det_s;
   assign pend_o    = pend_q;

   AST_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      change |=> pend_q); // R8
   AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i && !change |=> !pend_q); // R8

endmodule

// File: rtl/ci_card_bridge.sv
module ci_card_bridge
   import ci_bridge_pkg::*;
#(
   parameter int WAIT_CYCLES  = 4,
   parameter int RESET_CYCLES = 16,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_req,
   input  logic                 host_wr,
   input  logic [IDX_W-1:0]     host_addr,
   input  logic [HOST_DW-1:0]   host_wdata,
   output logic [HOST_DW-1:0]   host_rdata,
   output logic                 host_ready,
   output logic                 irq,
   output logic [CARD_AW-1:0]   card_addr,
   output logic [HOST_DW-1:0]   card_wdata,
   input  logic [HOST_DW-1:0]   card_rdata,
   output logic [NUM_SLOTS-1:0] card_ce_n,
   output logic                 card_ctl_space,
   output logic                 card_oe_n,
   output logic                 card_we_n,
   output logic [NUM_SLOTS-1:0] card_rst,
   input  logic [NUM_SLOTS-1:0] card_det_n,
   output logic [NUM_SLOTS-1:0] ts_en
);
   localparam int SEL_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

   if (ADDR_LO_W > HOST_DW - 1) begin : g_bad_lo
      $error("low address field does not fit above the unused bit");
   end
   if (ADDR_HI_W > HOST_DW) begin : g_bad_hi
      $error("high address field wider than a host byte");
   end

   logic [ADDR_LO_W-1:0]  addr_lo_q;
   logic [ADDR_HI_W-1:0]  addr_hi_q;
   logic                  slot_q;
   logic                  space_q;
   logic [NUM_SLOTS-1:0]  ts_q;
   logic [HOST_DW-1:0]    rdata_q;
   logic [HOST_DW-1:0]    ctrl_view;
   logic [NUM_SLOTS-1:0]  rst_start;
   logic [NUM_SLOTS-1:0]  rst_active;
   logic [NUM_SLOTS-1:0]  det_s;
   logic                  pend;
   logic                  cyc_busy;
   logic                  cyc_done;
   logic                  cyc_write;
   logic                  accept;
   logic                  wr_ctrl;
   logic                  start_cycle;
   logic                  clear_irq;

   assign accept      = host_req && host_ready;
   assign wr_ctrl     = accept && host_wr && (host_addr == RA_CTRL);
   assign start_cycle = accept && (host_addr == RA_DATA);
   assign clear_irq   = accept && !host_wr && (host_addr == RA_IRQ);

   // host-writable fields
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_lo_q <= '0;
         addr_hi_q <= '0;
         slot_q    <= 1'b0;
         space_q   <= 1'b0;
         ts_q      <= '0;
      end else if (accept && host_wr) begin
         case (host_addr)
            RA_ADDR_LO: addr_lo_q <= host_wdata[ADDR_LO_W:1];
            RA_ADDR_HI: addr_hi_q <= host_wdata[ADDR_HI_W-1:0];
            RA_CTRL: begin
               slot_q  <= host_wdata[CB_SLOT];
               space_q <= host_wdata[CB_SPACE];
               for (int s = 0; s < NUM_SLOTS; s++) ts_q[s] <= host_wdata[CB_TS0 - s];
            end
            default: ;
         endcase
      end
   end

   // control readback: per-slot fields run from slot 0 downwards
   always_comb begin
      ctrl_view           = '0;
      ctrl_view[CB_SLOT]  = slot_q;
      ctrl_view[CB_SPACE] = space_q;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         ctrl_view[CB_RST0 - s] = rst_active[s];
         ctrl_view[CB_TS0 - s]  = ts_q[s];
         ctrl_view[CB_DET0 - s] = det_s[s];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (cyc_done && !cyc_write) begin
         rdata_q <= card_rdata;
      end else if (accept && !host_wr) begin
         case (host_addr)
            RA_ADDR_LO: rdata_q <= {{(HOST_DW-ADDR_LO_W-1){1'b0}}, addr_lo_q, 1'b0};
            RA_ADDR_HI: rdata_q <= {{(HOST_DW-ADDR_HI_W){1'b0}}, addr_hi_q};
            RA_CTRL:    rdata_q <= ctrl_view;
            RA_IRQ:     rdata_q <= {{(HOST_DW-1){1'b0}}, pend};
            RA_DATA:    rdata_q <= rdata_q;
            default:    rdata_q <= '0;
         endcase
      end
   end

   ci_card_cycle #(
      .ADDR_W      (CARD_AW),
      .DATA_W      (HOST_DW),
      .SLOTS       (NUM_SLOTS),
      .WAIT_CYCLES (WAIT_CYCLES)
   ) u_cycle (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_cycle),
      .slot_i       (SEL_W'(slot_q)),
      .space_i      (space_q),
      .write_i      (host_wr),
      .addr_i       ({addr_hi_q, addr_lo_q}),
      .wdata_i      (host_wdata),
      .busy_o       (cyc_busy),
      .done_o       (cyc_done),
      .write_o      (cyc_write),
      .card_addr_o  (card_addr),
      .card_wdata_o (card_wdata),
      .card_ce_n_o  (card_ce_n),
      .card_space_o (card_ctl_space),
      .card_oe_n_o  (card_oe_n),
      .card_we_n_o  (card_we_n)
   );

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot_rst
      assign rst_start[s] = wr_ctrl && host_wdata[CB_RST0 - s];
      ci_slot_reset #(.RESET_CYCLES(RESET_CYCLES)) u_rst (
         .clk      (clk),
         .rst_n    (rst_n),
         .start_i  (rst_start[s]),
         .active_o (rst_active[s])
      );
   end

   ci_detect_mon #(
      .WIDTH       (NUM_SLOTS),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .det_n_i   (card_det_n),
      .clear_i   (clear_irq),
      .det_n_s_o (det_s),
      .pend_o    (pend)
   );

   assign host_ready = !cyc_busy;
   assign host_rdata = rdata_q;
   assign card_rst   = rst_active;
   assign ts_en      = ts_q;
   assign irq        = pend;

   AST_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (!card_oe_n || !card_we_n) |-> !host_ready); // R4
   AST_DATA_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      start_cycle |=> !host_ready); // R4
   AST_TS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> ts_en[0] == $past(host_wdata[CB_TS0])); // R6

endmodule

// File: tb/tb_ci_card_bridge.sv
module tb_ci_card_bridge;
   localparam int WAITC = 3;
   localparam int RSTC  = 6;
   localparam time CYC  = 20ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_req = 1'b0;
   logic       host_wr = 1'b0;
   logic [2:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       host_ready;
   logic       irq;
   logic [13:0] card_addr;
   logic [7:0] card_wdata;
   logic [7:0] card_rdata;
   logic [1:0] card_ce_n;
   logic       card_ctl_space;
   logic       card_oe_n;
   logic       card_we_n;
   logic [1:0] card_rst;
   logic [1:0] card_det_n = 2'b11;
   logic [1:0] ts_en;

   int checks = 0;
   int errors = 0;
   bit done_flag = 0;

   always #(CYC/2) clk = ~clk;

   ci_card_bridge #(.WAIT_CYCLES(WAITC), .RESET_CYCLES(RSTC), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_ready(host_ready), .irq(irq), .card_addr(card_addr),
      .card_wdata(card_wdata), .card_rdata(card_rdata), .card_ce_n(card_ce_n),
      .card_ctl_space(card_ctl_space), .card_oe_n(card_oe_n), .card_we_n(card_we_n),
      .card_rst(card_rst), .card_det_n(card_det_n), .ts_en(ts_en));

   function automatic logic [7:0] model(input logic [13:0] a, input logic sl, input logic sp);
      return a[7:0] ^ {a[13:8], 2'b00} ^ {sl, sp, 6'b0} ^ 8'h5A;
   endfunction

   // card model answers for whichever slot is selected
   always_comb card_rdata = model(card_addr, (card_ce_n == 2'b01), card_ctl_space);

   // pin monitor
   int          strobe_cnt;
   logic [13:0] obs_addr;
   logic        obs_slot, obs_space, obs_we;
   logic [7:0]  obs_wdata;
   int          rst_cnt [2];
   always @(posedge clk) begin
      if (!card_oe_n || !card_we_n) begin
         strobe_cnt++;
         obs_addr  = card_addr;
         obs_slot  = (card_ce_n == 2'b01);
         obs_space = card_ctl_space;
         obs_we    = !card_we_n;
         obs_wdata = card_wdata;
      end
      if (card_rst[0]) rst_cnt[0]++;
      if (card_rst[1]) rst_cnt[1]++;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic acc(input logic wr, input logic [2:0] ra, input logic [7:0] wd,
                      output logic [7:0] rd, output int waited);
      @(negedge clk);
      host_req = 1'b1; host_wr = wr; host_addr = ra; host_wdata = wd;
      @(negedge clk);
      host_req = 1'b0;
      waited = 0;
      while (!host_ready) begin @(negedge clk); waited++; end
      rd = host_rdata;
   endtask

   task automatic wr_reg(input logic [2:0] ra, input logic [7:0] wd);
      logic [7:0] d; int w;
      acc(1'b1, ra, wd, d, w);
   endtask

   task automatic rd_reg(input logic [2:0] ra, output logic [7:0] rd);
      int w;
      acc(1'b0, ra, 8'h00, rd, w);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #(CYC * 100000);
      if (!done_flag) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] rd;
      int w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R4 reset ready", host_ready, 1);
      chk("R2 reset ce_n", card_ce_n, 2'b11);
      chk("R5 reset card_rst", card_rst, 2'b00);
      chk("R8 reset irq", irq, 0);
      chk("R6 reset ts_en", ts_en, 2'b00);
      rd_reg(3'd3, rd);
      chk("R7 reset ctrl", rd, 8'h03);

      // address / slot / space sweep with reads and writes
      for (int i = 0; i < 18; i++) begin
         logic [13:0] a;
         a = (i == 0) ? 14'h0000 : (i == 1) ? 14'h3FFF : 14'((i * 16'h2B7 + 16'h15));
         for (int m = 0; m < 4; m++) begin
            logic sl, sp;
            logic [7:0] wv;
            sl = m[1]; sp = m[0];
            wr_reg(3'd0, {a[6:0], i[0]});
            wr_reg(3'd1, {i[1], a[13:7]});
            wr_reg(3'd3, {sl, sp, 6'b0});
            strobe_cnt = 0;
            acc(1'b0, 3'd2, 8'h00, rd, w);
            chk("R1 card address", obs_addr, a);
            chk("R2 slot select", obs_slot, sl);
            chk("R2 space select", obs_space, sp);
            chk("R3 read strobe", obs_we, 0);
            chk("R4 read data", rd, model(a, sl, sp));
            chk("R4 strobe length", strobe_cnt, WAITC);
            chk("R4 ready low cycles", w, WAITC);
            wv = 8'(a[7:0] + 8'(m * 37));
            strobe_cnt = 0;
            acc(1'b1, 3'd2, wv, rd, w);
            chk("R3 write strobe", obs_we, 1);
            chk("R3 write data", obs_wdata, wv);
            chk("R3 write length", strobe_cnt, WAITC);
         end
         rd_reg(3'd0, rd);
         chk("R1 LO readback", rd, {a[6:0], 1'b0});
         rd_reg(3'd1, rd);
         chk("R1 HI readback", rd, {1'b0, a[13:7]});
      end

      // R6 transport stream enables
      wr_reg(3'd3, 8'h08); @(negedge clk);
      chk("R6 ts slot0", ts_en, 2'b01);
      wr_reg(3'd3, 8'h04); @(negedge clk);
      chk("R6 ts slot1", ts_en, 2'b10);
      wr_reg(3'd3, 8'h0C); @(negedge clk);
      chk("R6 ts both", ts_en, 2'b11);
      wr_reg(3'd3, 8'h00);

      // R5 per-slot reset
      rst_cnt[0] = 0; rst_cnt[1] = 0;
      wr_reg(3'd3, 8'h20);
      rd_reg(3'd3, rd);
      chk("R5 slot0 busy bit", rd & 8'h30, 8'h20);
      repeat (RSTC + 4) @(negedge clk);
      chk("R5 slot0 length", rst_cnt[0], RSTC);
      chk("R5 slot1 untouched", rst_cnt[1], 0);
      rd_reg(3'd3, rd);
      chk("R5 slot0 self clear", rd & 8'h30, 8'h00);
      rst_cnt[0] = 0;
      wr_reg(3'd3, 8'h10);
      wr_reg(3'd3, 8'h00);
      rd_reg(3'd3, rd);
      chk("R5 slot1 busy after 0 write", rd & 8'h30, 8'h10);
      repeat (RSTC + 4) @(negedge clk);
      chk("R5 slot1 length", rst_cnt[1], RSTC);
      chk("R5 slot0 untouched", rst_cnt[0], 0);

      // R7 / R8 card detect
      rd_reg(3'd4, rd);
      chk("R8 no pending", rd, 8'h00);
      card_det_n = 2'b10;
      repeat (6) @(negedge clk);
      chk("R8 irq raised", irq, 1);
      rd_reg(3'd3, rd);
      chk("R7 status slot0 present", rd & 8'h03, 8'h01);
      wr_reg(3'd3, 8'h03);
      rd_reg(3'd3, rd);
      chk("R7 status write ignored", rd, 8'h01);
      rd_reg(3'd4, rd);
      chk("R8 pending read", rd, 8'h01);
      @(negedge clk);
      chk("R8 irq cleared", irq, 0);
      rd_reg(3'd4, rd);
      chk("R8 stays clear", rd, 8'h00);
      card_det_n = 2'b01;
      repeat (6) @(negedge clk);
      chk("R8 irq second change", irq, 1);
      rd_reg(3'd3, rd);
      chk("R7 status slot1 present", rd & 8'h03, 8'h02);

      done_flag = 1;
      summary();
      $finish;
   end
endmodule